// File: doc/BRIEF.md
# Four-Channel One-Shot Alarm Comparator with Interrupts

This block holds four independent alarm channels. Each channel keeps a 32-bit target value and an armed flag. While a channel is armed, its target is compared with the low 32-bit word of a free-running microsecond time value that a separate counter supplies on `time_lo`. When the two are equal, the channel fires exactly once. Firing clears the channel's armed flag and latches its raw interrupt bit.

Software talks to the block through a single-cycle register write port and a combinational read port. Storing a target re-arms its channel. Writing ones to the armed-status register cancels the chosen alarms at once, and they do not fire. The raw interrupt bits clear when ones are written to them. An enable mask and a force register are combined with the raw bits to form a status word, and that word drives one interrupt line per channel.

Register addresses on `wr_addr` and `rd_addr`: 0 to 3 are the channel targets, 8 is armed status, 9 is raw interrupts, 10 is enable, 11 is force and 12 is masked status (read-only). Bit i of the 4-bit registers belongs to channel i. Every other address reads as zero and ignores writes.

Top module: `alarm_irq_unit`

## Requirements
- R1: After synchronous reset, the armed, raw, enable and force registers read 0 and every `irq` line is low.
- R2: A write to address i (0 to 3) stores `wr_data` as the target of channel i, and the next cycle shows the channel armed (armed register bit i = 1). The target reads back unchanged from address i.
- R3: When channel i is armed and its target equals `time_lo` in a cycle, then one cycle later armed bit i is 0 and raw bit i (address 9) is 1.
- R4: A channel that is not armed never sets its raw bit, even when its target equals `time_lo`.
- R5: Writing address 8 clears the armed bits where `wr_data` has ones and leaves the other bits unchanged. If that write falls in the same cycle as a match on a bit it clears, the channel does not fire and its raw bit is unchanged.
- R6: Writing address 9 clears the raw bits where `wr_data` has ones. If channel i fires in the same cycle that raw bit i is being cleared, the bit stays 1.
- R7: Addresses 10 (enable) and 11 (force) are plain read/write 4-bit registers. Address 12 reads (raw OR force) AND enable.
- R8: `irq[i]` equals bit i of the status word, so it is high only when enable bit i is set and either raw bit i or force bit i is set.
- R9: A target write to channel i in the same cycle as a match on channel i leaves the channel armed with the new target, and raw bit i is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| time_lo | input | 32 | Low word of the microsecond time |
| irq | output | 4 | Per-channel interrupt lines (masked status) |

## Verification
The time input is stepped forward, held still, and brought to several different targets. This shows that a fire happens only on exact equality and only once per arming, not on every cycle the value stays equal. Matches are also driven into channels that are disarmed, so an equality that should be ignored can be told apart from one that counts. Single-cycle collisions put a disarm write, a raw-clear write and a target rewrite on the very cycle of a match, which shows the priority of each. Enable and force patterns are then varied with raw bits both set and clear, so masking and forcing can be separated on the interrupt lines.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NUM_ALARMS = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] A_ARMED  = 4'd8;
    localparam logic [ADDR_W-1:0] A_RAW    = 4'd9;
    localparam logic [ADDR_W-1:0] A_ENABLE = 4'd10;
    localparam logic [ADDR_W-1:0] A_FORCE  = 4'd11;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd12;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    typedef logic [NUM_ALARMS-1:0] chan_vec_t;

    function automatic logic hits(wreq_t r, logic [ADDR_W-1:0] a);
        return r.we && (r.addr == a);
    endfunction

    function automatic chan_vec_t ones_if(wreq_t r, logic [ADDR_W-1:0] a);
        return hits(r, a) ? r.data[NUM_ALARMS-1:0] : '0;
    endfunction
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
    import alarm_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  wreq_t             wreq,
    input  logic [DATA_W-1:0] time_lo,
    output logic [DATA_W-1:0] target,
    output logic              armed,
    output logic              fire
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

    logic load, cancel, match;

    assign load   = hits(wreq, MY_ADDR);
    assign cancel = hits(wreq, A_ARMED) && wreq.data[IDX];
    assign match  = armed && (target == time_lo);
    assign fire   = match && !cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            armed  <= 1'b0;
        end else begin
            if (load) target <= wreq.data;
            if (load)        armed <= 1'b1;
            else if (cancel) armed <= 1'b0;
            else if (fire)   armed <= 1'b0;
        end
    end
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank
    import alarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wreq_t     wreq,
    input  chan_vec_t fire,
    output chan_vec_t raw,
    output chan_vec_t enable,
    output chan_vec_t force_r,
    output chan_vec_t status
);
    chan_vec_t clr;

    assign clr    = ones_if(wreq, A_RAW);
    assign status = (raw | force_r) & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw     <= '0;
            enable  <= '0;
            force_r <= '0;
        end else begin
            raw <= (raw & ~clr) | fire;
            if (hits(wreq, A_ENABLE)) enable  <= wreq.data[NUM_ALARMS-1:0];
            if (hits(wreq, A_FORCE))  force_r <= wreq.data[NUM_ALARMS-1:0];
        end
    end
endmodule

// File: rtl/alarm_read_mux.sv
module alarm_read_mux
    import alarm_pkg::*;
(
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NUM_ALARMS*DATA_W-1:0] targets,
    input  chan_vec_t                    armed,
    input  chan_vec_t                    raw,
    input  chan_vec_t                    enable,
    input  chan_vec_t                    force_r,
    input  chan_vec_t                    status,
    output logic [DATA_W-1:0]            rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_ALARMS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = targets[i*DATA_W +: DATA_W];
        end
        case (rd_addr)
            A_ARMED:  rd_data = DATA_W'(armed);
            A_RAW:    rd_data = DATA_W'(raw);
            A_ENABLE: rd_data = DATA_W'(enable);
            A_FORCE:  rd_data = DATA_W'(force_r);
            A_STATUS: rd_data = DATA_W'(status);
            default:  ;
        endcase
    end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [DATA_W-1:0]     time_lo,
    output logic [NUM_ALARMS-1:0] irq
);
    wreq_t                          wreq;
    chan_vec_t                      armed_vec, fire_vec;
    chan_vec_t                      raw, enable, force_r, status;
    logic [NUM_ALARMS*DATA_W-1:0]   targets;

    assign wreq = '{we: wr_en, addr: wr_addr, data: wr_data};

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_slot
        alarm_slot #(.IDX(g)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wreq    (wreq),
            .time_lo (time_lo),
            .target  (targets[g*DATA_W +: DATA_W]),
            .armed   (armed_vec[g]),
            .fire    (fire_vec[g])
        );
    end

    alarm_irq_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wreq    (wreq),
        .fire    (fire_vec),
        .raw     (raw),
        .enable  (enable),
        .force_r (force_r),
        .status  (status)
    );

    alarm_read_mux u_rd (
        .rd_addr (rd_addr),
        .targets (targets),
        .armed   (armed_vec),
        .raw     (raw),
        .enable  (enable),
        .force_r (force_r),
        .status  (status),
        .rd_data (rd_data)
    );

    assign irq = status;
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk
    import alarm_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic [DATA_W-1:0]            time_lo,
    input logic [NUM_ALARMS*DATA_W-1:0] targets,
    input logic [NUM_ALARMS-1:0]        armed,
    input logic [NUM_ALARMS-1:0]        raw,
    input logic [NUM_ALARMS-1:0]        enable,
    input logic [NUM_ALARMS-1:0]        force_r,
    input logic [NUM_ALARMS-1:0]        irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (armed == '0 && raw == '0 && irq == '0)); // R1

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
        AST_ARM_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(i)) |=> armed[i]); // R2

        AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
            (armed[i] && targets[i*DATA_W +: DATA_W] == time_lo &&
             !(wr_en && (wr_addr == ADDR_W'(i) || wr_addr == A_ARMED)))
            |=> (!armed[i] && raw[i])); // R3

        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            (!armed[i] && !raw[i]) |=> !raw[i]); // R4

        AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == A_ARMED && wr_data[i]) |=> (!armed[i] && raw[i] == $past(raw[i]))); // R5

        AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
            (raw[i] && !(wr_en && wr_addr == A_RAW && wr_data[i])) |=> raw[i]); // R6

        AST_MASKED_LOW: assert property (@(posedge clk) disable iff (rst)
            !enable[i] |-> !irq[i]); // R8

        AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
            (enable[i] && force_r[i]) |-> irq[i]); // R7
    end
endmodule

bind alarm_irq_unit alarm_irq_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .time_lo (time_lo),
    .targets (targets),
    .armed   (armed_vec),
    .raw     (raw),
    .enable  (enable),
    .force_r (force_r),
    .irq     (irq)
);

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] time_lo = 32'd1;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    alarm_irq_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .time_lo(time_lo), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_tgt [N];
    logic [3:0]  m_armed, m_raw, m_en, m_frc;

    always @(posedge clk) begin
        logic [3:0] fire;
        logic [3:0] cancel;
        if (rst) begin
            for (int i = 0; i < N; i++) m_tgt[i] = '0;
            m_armed = '0; m_raw = '0; m_en = '0; m_frc = '0;
        end else begin
            cancel = (wr_en && wr_addr == 4'd8) ? wr_data[3:0] : 4'b0;
            for (int i = 0; i < N; i++)
                fire[i] = m_armed[i] && (m_tgt[i] == time_lo) && !cancel[i];
            if (wr_en && wr_addr == 4'd9) m_raw = m_raw & ~wr_data[3:0];
            m_raw = m_raw | fire;
            for (int i = 0; i < N; i++) begin
                if (wr_en && wr_addr == 4'(i)) begin
                    m_tgt[i] = wr_data;
                    m_armed[i] = 1'b1;
                end else if (cancel[i] || fire[i]) begin
                    m_armed[i] = 1'b0;
                end
            end
            if (wr_en && wr_addr == 4'd10) m_en  = wr_data[3:0];
            if (wr_en && wr_addr == 4'd11) m_frc = wr_data[3:0];
        end
    end

    function automatic logic [31:0] m_read(logic [3:0] a);
        if (a < 4) return m_tgt[a[1:0]];
        case (a)
            4'd8:  return {28'b0, m_armed};
            4'd9:  return {28'b0, m_raw};
            4'd10: return {28'b0, m_en};
            4'd11: return {28'b0, m_frc};
            4'd12: return {28'b0, (m_raw | m_frc) & m_en};
            default: return 32'b0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] er;
        logic [3:0]  ei;
        er = m_read(rd_addr);
        ei = (m_raw | m_frc) & m_en;
        checks++;
        if (rd_data !== er) begin
            failures++;
            $display("FAIL %s rd_addr=%0d rd_data=%h expected %h", cur_req, rd_addr, rd_data, er);
        end
        checks++;
        if (irq !== ei) begin
            failures++;
            $display("FAIL %s irq=%b expected %b", cur_req, irq, ei);
        end
    endtask

    // one cycle: check outputs from previous edge, then drive the next inputs
    task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic [3:0] ra, input logic [31:0] t);
        @(negedge clk);
        compare();
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; time_lo = t;
    endtask

    task automatic rd(input logic [3:0] ra, input logic [31:0] t);
        step(1'b0, 4'd0, 32'd0, ra, t);
    endtask

    task automatic sweep(input logic [31:0] t);
        for (int a = 0; a < 13; a++) rd(4'(a), t);
        rd(4'd14, t);
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        sweep(32'd1);

        cur_req = "R7";
        step(1'b1, 4'd10, 32'hF, 4'd10, 32'd2);
        step(1'b1, 4'd11, 32'h0, 4'd11, 32'd3);
        rd(4'd12, 32'd4);

        cur_req = "R2";
        step(1'b1, 4'd0, 32'd100, 4'd8, 32'd50);
        rd(4'd0, 32'd51);
        rd(4'd8, 32'd52);

        cur_req = "R3";
        for (int t = 97; t < 103; t++) rd(4'd8, 32'(t));
        rd(4'd9, 32'd103);
        cur_req = "R8";
        rd(4'd12, 32'd104);
        // holding time at target after firing must not refire
        cur_req = "R3";
        step(1'b1, 4'd9, 32'h1, 4'd9, 32'd100);
        rd(4'd9, 32'd100);
        rd(4'd9, 32'd100);

        cur_req = "R4";
        step(1'b1, 4'd1, 32'd200, 4'd8, 32'd150);
        step(1'b1, 4'd8, 32'h2, 4'd8, 32'd151);
        rd(4'd9, 32'd200);
        rd(4'd9, 32'd200);
        rd(4'd8, 32'd201);

        cur_req = "R5";
        step(1'b1, 4'd2, 32'd300, 4'd8, 32'd290);
        step(1'b1, 4'd3, 32'd999, 4'd8, 32'd291);
        step(1'b1, 4'd8, 32'h4, 4'd8, 32'd300);
        rd(4'd9, 32'd301);
        rd(4'd8, 32'd302);
        step(1'b1, 4'd8, 32'h0, 4'd8, 32'd303);
        rd(4'd8, 32'd304);

        cur_req = "R6";
        step(1'b1, 4'd3, 32'd400, 4'd8, 32'd398);
        rd(4'd9, 32'd399);
        step(1'b1, 4'd9, 32'h8, 4'd9, 32'd400);
        rd(4'd9, 32'd401);
        step(1'b1, 4'd9, 32'hF, 4'd9, 32'd402);
        rd(4'd9, 32'd403);

        cur_req = "R7";
        step(1'b1, 4'd11, 32'h2, 4'd12, 32'd404);
        step(1'b1, 4'd10, 32'h0, 4'd12, 32'd405);
        rd(4'd12, 32'd406);
        cur_req = "R8";
        step(1'b1, 4'd10, 32'hA, 4'd12, 32'd407);
        step(1'b1, 4'd11, 32'h0, 4'd12, 32'd408);
        rd(4'd12, 32'd409);

        cur_req = "R9";
        step(1'b1, 4'd0, 32'd500, 4'd8, 32'd490);
        step(1'b1, 4'd0, 32'd600, 4'd8, 32'd500);
        rd(4'd8, 32'd501);
        rd(4'd9, 32'd502);
        rd(4'd0, 32'd600);
        rd(4'd9, 32'd601);

        cur_req = "R2";
        step(1'b1, 4'd1, 32'hDEAD_BEEF, 4'd1, 32'd700);
        step(1'b1, 4'd2, 32'h1234_5678, 4'd2, 32'd701);
        sweep(32'd702);

        cur_req = "R1";
        rst = 1'b1;
        rd(4'd8, 32'd703);
        rd(4'd9, 32'd704);
        rst = 1'b0;
        sweep(32'd705);

        @(negedge clk);
        compare();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule